// File: doc/BRIEF.md
# Multi-Rail Power-Good Aggregator

This block watches eight supply rails through two digital flags per rail: an enable, and an in-window flag from an analog comparator that is high while the rail's feedback sits within 7% of its reference. Each rail is qualified on its own. It must stay in window for a full settling interval before it is reported good. Once good, it must stay out of window for a short deglitch interval before it is reported low. Both intervals are counted on a 1 µs tick enable. The default counts are 250 ticks for the settling interval and 25 ticks for the deglitch.

The qualified per-rail bits form an eight-bit status byte, with a fixed mapping of rails to bits. A combined power-good output is high only when at least one rail is enabled and every enabled rail is qualified good. With no rail enabled, the combined output and every status bit are low. A disabled rail reads 0 and plays no part in the combined output. Software reads the status byte and the combined output through a small address and read-strobe port.

Top module: `pgood_agg`

## Requirements
- R1: After synchronous reset, every status bit is 0, `pg_out` is 0 and `rd_data` is 0.
- R2: An enabled rail's status bit becomes 1 on the tick on which its in-window flag has been high for GOOD_TICKS consecutive ticks (default 250), and not on any earlier tick. Bit mapping: bit0 standby LDO, bit1–bit3 step-down regulators 1–3, bit4 buck-boost regulator, bit5–bit7 LDO2–LDO4. A 1 means good.
- R3: If the in-window flag drops during any cycle before the settling count completes, the count restarts from zero.
- R4: A good rail whose in-window flag is low for LOW_TICKS consecutive ticks (default 25) reports 0 on that tick. A dip shorter than that leaves the bit at 1.
- R5: A disabled rail's status bit reads 0 one cycle after its enable falls, and the rail is excluded from `pg_out`.
- R6: `pg_out` is 1 exactly when at least one rail is enabled and all enabled rails are reported good. It follows the status bits one cycle later.
- R7: With no rail enabled, `pg_out` is 0 and the status byte is 0, whatever the in-window flags do.
- R8: A read strobe returns data one cycle later. Address 0 returns the status byte. Address 1 returns `pg_out` in bit0 with the other bits 0. Addresses 2 and 3 return 0. With no strobe, `rd_data` is 0.
- R9: The counts advance only on cycles where `tick_us` is high. With no tick, no rail becomes good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| rail_en | input | NUM_RAILS | Per-rail enable flags |
| rail_ok | input | NUM_RAILS | Per-rail in-window comparator flags |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | NUM_RAILS | Read data, one cycle after the strobe |
| pg_out | output | 1 | Combined power-good output |

## Verification
A status bit changes at the clock edge that samples the completing tick. `pg_out` follows one edge later, and read data appears one edge after the strobe. The bench drives ticks, flags and strobes at falling edges and samples there. It checks a status bit in the first half-cycle after the completing tick and `pg_out` one full cycle later. Read results go through a queue that the monitor drains one cycle after each strobe. Boundary checks are placed one tick before and exactly at each count limit.

// File: rtl/pga_pkg.sv
package pga_pkg;
    localparam int RAIL_COUNT   = 8;
    localparam int ADDR_STATUS  = 0;
    localparam int ADDR_SUMMARY = 1;

    // Fixed rail-to-bit positions of the status byte
    typedef enum int unsigned {
        BIT_LDO_STBY   = 0,
        BIT_STEPDN1    = 1,
        BIT_STEPDN2    = 2,
        BIT_STEPDN3    = 3,
        BIT_BUCKBOOST  = 4,
        BIT_LDO2       = 5,
        BIT_LDO3       = 6,
        BIT_LDO4       = 7
    } rail_bit_e;
endpackage

// File: rtl/pga_rail_qual.sv
module pga_rail_qual #(
    parameter int LOW_TICKS  = 25,
    parameter int GOOD_TICKS = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    input  logic ok,
    output logic good
);
    localparam int MAXC = (GOOD_TICKS > LOW_TICKS) ? GOOD_TICKS : LOW_TICKS;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          good;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.good = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.good) begin
            // deglitch window before reporting low
            if (ok) begin
                s_d.cnt = '0;
            end else if (tick) begin
                if (s_q.cnt == CW'(LOW_TICKS - 1)) begin
                    s_d.good = 1'b0;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else begin
            // settling window before reporting good; restarts on any drop
            if (!ok) begin
                s_d.cnt = '0;
            end else if (tick) begin
                if (s_q.cnt == CW'(GOOD_TICKS - 1)) begin
                    s_d.good = 1'b1;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign good = s_q.good;
endmodule

// File: rtl/pga_rdport.sv
module pga_rdport import pga_pkg::*; #(
    parameter int DW     = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     status,
    input  logic              pg,
    output logic [DW-1:0]     rd_data
);
    typedef struct packed {
        logic [DW-1:0] data;
    } rd_t;

    rd_t r_d, r_q;

    always_comb begin
        r_d.data = '0;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(ADDR_STATUS))
                r_d.data = status;
            else if (rd_addr == ADDR_W'(ADDR_SUMMARY))
                r_d.data = DW'(pg);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rd_data = r_q.data;
endmodule

// File: rtl/pgood_agg.sv
module pgood_agg import pga_pkg::*; #(
    parameter int NUM_RAILS  = RAIL_COUNT,
    parameter int LOW_TICKS  = 25,
    parameter int GOOD_TICKS = 250,
    parameter int ADDR_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_us,
    input  logic [NUM_RAILS-1:0] rail_en,
    input  logic [NUM_RAILS-1:0] rail_ok,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [NUM_RAILS-1:0] rd_data,
    output logic                 pg_out
);
    logic [NUM_RAILS-1:0] status_q;

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        pga_rail_qual #(
            .LOW_TICKS  (LOW_TICKS),
            .GOOD_TICKS (GOOD_TICKS)
        ) i_qual (
            .clk  (clk),
            .rst  (rst),
            .tick (tick_us),
            .en   (rail_en[i]),
            .ok   (rail_ok[i]),
            .good (status_q[i])
        );
    end

    typedef struct packed {
        logic pg;
    } sum_t;

    sum_t m_d, m_q;

    always_comb begin
        m_d.pg = (|rail_en) && (&(status_q | ~rail_en));
    end

    always_ff @(posedge clk) begin
        if (rst) m_q <= '0;
        else     m_q <= m_d;
    end

    assign pg_out = m_q.pg;

    pga_rdport #(
        .DW     (NUM_RAILS),
        .ADDR_W (ADDR_W)
    ) i_rdport (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .status  (status_q),
        .pg      (m_q.pg),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/pgood_agg_chk.sv
module pgood_agg_chk #(
    parameter int NUM_RAILS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_us,
    input logic [NUM_RAILS-1:0] rail_en,
    input logic [NUM_RAILS-1:0] rail_ok,
    input logic                 rd_en,
    input logic [NUM_RAILS-1:0] rd_data,
    input logic                 pg_out,
    input logic [NUM_RAILS-1:0] status
);
    AST_DISABLED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(rail_en)) == '0));                        // R5

    AST_NONE_ENABLED_PG_LOW: assert property (@(posedge clk) disable iff (rst)
        (rail_en == '0) |=> !pg_out);                                         // R7

    AST_PG_NEEDS_ALL_GOOD: assert property (@(posedge clk) disable iff (rst)
        pg_out |-> (($past(rail_en) & ~$past(status)) == '0));                // R6

    AST_RISE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status)) != '0) |-> $past(tick_us));                // R9

    AST_RISE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(rail_ok)) == '0));        // R2

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));                                          // R8
endmodule

bind pgood_agg pgood_agg_chk #(.NUM_RAILS(NUM_RAILS)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_us (tick_us),
    .rail_en (rail_en),
    .rail_ok (rail_ok),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pg_out  (pg_out),
    .status  (status_q)
);

// File: tb/test_pgood_agg.sv
`timescale 1ns/1ps
module test_pgood_agg;
    localparam int N     = 8;
    localparam int LOWT  = 25;
    localparam int GOODT = 250;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_us = 1'b0;
    logic [N-1:0] rail_en = '0;
    logic [N-1:0] rail_ok = '0;
    logic         rd_en = 1'b0;
    logic [1:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         pg_out;

    int nvec = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    pgood_agg #(.NUM_RAILS(N), .LOW_TICKS(LOWT), .GOOD_TICKS(GOODT), .ADDR_W(2)) i_pgood_agg (
        .clk(clk), .rst(rst), .tick_us(tick_us), .rail_en(rail_en), .rail_ok(rail_ok),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pg_out(pg_out)
    );

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } rd_item_t;

    rd_item_t rd_q[$];

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // driver: issue a read strobe and queue the expected result
    task automatic do_read(logic [1:0] addr, logic [N-1:0] exp, string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        rd_q.push_back(it);
        rd_en   = 1'b1;
        rd_addr = addr;
        @(negedge clk);
        rd_en   = 1'b0;
        rd_addr = '0;
        @(negedge clk);
    endtask

    // monitor: one cycle after a sampled strobe, compare against the queue
    logic rd_fire = 1'b0;
    always @(posedge clk) rd_fire <= rd_en;
    always @(negedge clk) begin
        if (rd_fire) begin
            if (rd_q.size() == 0) begin
                nvec++;
                nerr++;
                $display("FAIL R8: unexpected read data %02h", rd_data);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                check(it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick_us = 1'b1;
            @(negedge clk);
            tick_us = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // completing tick with status checked right after and pg one cycle later
    task automatic final_tick(logic [N-1:0] st_exp, logic pg_before, logic pg_after, string tag);
        tick_us = 1'b1;
        @(negedge clk);
        tick_us = 1'b0;
        check({tag, " pg before"}, N'(pg_out), N'(pg_before));
        @(negedge clk);
        check({tag, " pg after"}, N'(pg_out), N'(pg_after));
        repeat (2) @(negedge clk);
        do_read(2'd0, st_exp, {tag, " status"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pg reset", N'(pg_out), '0);
        check("R1 rd_data reset", rd_data, '0);
        do_read(2'd0, 8'h00, "R1 status reset");
        do_read(2'd1, 8'h00, "R1 summary reset");

        // R7: flags high but nothing enabled
        rail_ok = '1;
        ticks(GOODT + 10);
        check("R7 pg none enabled", N'(pg_out), '0);
        do_read(2'd0, 8'h00, "R7 status none enabled");

        // R2: buck-boost (bit4) alone
        rail_en = 8'h10;
        rail_ok = 8'h10;
        ticks(GOODT - 1);
        do_read(2'd0, 8'h00, "R2 one tick early");
        check("R2 pg early", N'(pg_out), '0);
        final_tick(8'h10, 1'b0, 1'b1, "R6 bit4 good");
        do_read(2'd1, 8'h01, "R8 summary high");

        // R9: no tick, no progress on standby LDO (bit0)
        rail_en = 8'h11;
        rail_ok = 8'h11;
        @(negedge clk);
        @(negedge clk);
        check("R6 pg low with unqualified rail", N'(pg_out), '0);
        repeat (2000) @(negedge clk);
        do_read(2'd0, 8'h10, "R9 no tick no progress");

        // R3: drop during settling restarts
        ticks(100);
        rail_ok = 8'h10;
        @(negedge clk);
        rail_ok = 8'h11;
        ticks(GOODT - 1);
        do_read(2'd0, 8'h10, "R3 restart not done");
        final_tick(8'h11, 1'b0, 1'b1, "R3 restart done");

        // R4: short dip on bit4 is ignored
        rail_ok = 8'h01;
        ticks(LOWT - 1);
        rail_ok = 8'h11;
        ticks(2);
        do_read(2'd0, 8'h11, "R4 short dip kept");
        check("R4 pg after short dip", N'(pg_out), 1'b1);
        // long dip clears it
        rail_ok = 8'h01;
        ticks(LOWT - 1);
        do_read(2'd0, 8'h11, "R4 dip one tick short");
        final_tick(8'h01, 1'b1, 1'b0, "R4 dip reported");
        rail_ok = 8'h11;
        ticks(GOODT);
        do_read(2'd0, 8'h11, "R4 recovered");

        // R5: disabling bit0 clears it, excluded from pg
        rail_en = 8'h10;
        @(negedge clk);
        do_read(2'd0, 8'h10, "R5 disabled reads zero");
        check("R5 pg excludes disabled", N'(pg_out), 1'b1);

        // all eight rails
        rail_en = 8'hFF;
        rail_ok = 8'hFF;
        ticks(GOODT);
        do_read(2'd0, 8'hFF, "R2 all rails");
        check("R6 pg all rails", N'(pg_out), 1'b1);
        do_read(2'd2, 8'h00, "R8 addr2");
        do_read(2'd3, 8'h00, "R8 addr3");

        // R7: disable all
        rail_en = 8'h00;
        @(negedge clk);
        @(negedge clk);
        check("R7 pg after disable all", N'(pg_out), '0);
        do_read(2'd0, 8'h00, "R7 status after disable all");
        check("R8 idle rd_data", rd_data, '0);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule